// File: doc/BRIEF.md
# Power-On and Pushbutton Reset Sequencer

This block is a synchronous reset supervisor. It takes a supply-good flag from an external voltage comparator and an active-low pushbutton, and from them it produces a pair of complementary system resets. Each reset pulse has a guaranteed minimum width. A trip-tolerance select line passes straight through to the comparator, so the comparator can pick between its two thresholds.

Both asynchronous inputs go through two-flop synchronizers before any timing logic uses them. The synchronized supply-good flag also clears all internal state at once, so a power failure asserts reset without a filter delay. A pushbutton press counts only after the button has stayed low for the debounce window. Reset then stays asserted for as long as the button is held, and for the full hold window after it is released. The same hold window follows every return of the supply.

The debounce window and the hold window are computed from a clock-frequency parameter (`CLK_HZ`, with `DEB_MS` = 20 and `HOLD_MS` = 250). From these, DEB_CYC = CLK_HZ/1000*DEB_MS and HOLD_CYC = CLK_HZ/1000*HOLD_MS. No pin carries data, so every port is a plain control level with no handshake.

Top module: `rst_supervisor`

## Requirements
- R1: `sys_rst` is the logical complement of `sys_rst_n` at every sampled instant.
- R2: While `pwr_ok_async` is 0, reset is asserted (`sys_rst_n` = 0). The assertion takes effect without waiting for a clock edge, and it holds from the initial state onward.
- R3: Let edge 1 be the first rising clock edge that samples `pwr_ok_async` = 1. With the button released, `sys_rst_n` goes to 1 right after edge HOLD_CYC+2, and not before.
- R4: Let edge 1 be the first edge that samples `btn_n_async` = 0, and let the button stay low for L edges. The press is qualified exactly when L >= DEB_CYC. A qualified press drives `sys_rst_n` to 0 right after edge DEB_CYC+3.
- R5: After a qualified press, `sys_rst_n` stays 0 while the button is low. It returns to 1 right after edge L+HOLD_CYC+3, counted as in R4.
- R6: A press with L < DEB_CYC has no effect: `sys_rst_n` stays 1 throughout and after it.
- R7: A new qualified press during the hold window restarts the hold timer. The release then follows R5, counted from the new press. A supply dropout during the hold window restarts it as well, and the release then follows R3, counted from the supply's return.
- R8: `thr_sel_o` equals `tol_sel` at all times. Here 0 selects the higher trip threshold and 1 the lower one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| pwr_ok_async | input | 1 | Asynchronous supply-good flag from the comparator, 1 = supply above trip point |
| tol_sel | input | 1 | Trip-tolerance select, 0 = higher threshold, 1 = lower threshold |
| btn_n_async | input | 1 | Asynchronous pushbutton, 0 = pressed |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high, complement of `sys_rst_n` |
| thr_sel_o | output | 1 | Threshold select forwarded to the comparator |

## Verification
A hold counter that starts or ends one count off moves the rising edge of `sys_rst_n` by one clock. The exact release edges checked after power-up, after button release and after a retrigger catch that on the first pulse. A debounce counter with the wrong limit shows up inside the sweep over press lengths: one length either side of DEB_CYC gets the wrong qualification, and the fault is visible within a few cycles of that press. A qualification flag that fails to clear, or a timer that fails to restart, leaves reset stuck low or releases it early in the retrigger and dropout scenarios, well within one hold window.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef enum logic {SEQ_HOLD = 1'b0, SEQ_RUN = 1'b1} seq_state_t;

  function automatic int ms_to_cycles(input int clk_hz, input int ms);
    return (clk_hz / 1000) * ms;
  endfunction
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= {STAGES{RST_VAL}};
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic btn_n_s,
  output logic pressed
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] low_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_cnt <= '0;
      pressed <= 1'b0;
    end else if (btn_n_s) begin
      low_cnt <= '0;
      pressed <= 1'b0;
    end else if (!pressed) begin
      if (low_cnt == LAST) pressed <= 1'b1;
      else                 low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rsup_hold_seq.sv
module rsup_hold_seq
  import rsup_pkg::*;
#(
  parameter int LIMIT = 250
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold_req,
  output logic rst_n
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  seq_state_t   state;
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= SEQ_HOLD;
      cnt   <= '0;
    end else if (hold_req) begin
      state <= SEQ_HOLD;
      cnt   <= '0;
    end else if (state == SEQ_HOLD) begin
      if (cnt == LAST) begin
        state <= SEQ_RUN;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rst_n = (state == SEQ_RUN);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsup_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int DEB_MS      = 20,
  parameter int HOLD_MS     = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pwr_ok_async,
  input  logic tol_sel,
  input  logic btn_n_async,
  output logic sys_rst_n,
  output logic sys_rst,
  output logic thr_sel_o
);
  localparam int DEB_CYC  = ms_to_cycles(CLK_HZ, DEB_MS);
  localparam int HOLD_CYC = ms_to_cycles(CLK_HZ, HOLD_MS);

  logic pwr_s;
  logic btn_s;
  logic btn_qual;
  logic seq_rst_n;

  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
    .clk(clk), .arst_n(pwr_ok_async), .d(1'b1), .q(pwr_s)
  );

  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_btn_sync (
    .clk(clk), .arst_n(pwr_s), .d(btn_n_async), .q(btn_s)
  );

  rsup_debounce #(.LIMIT(DEB_CYC)) u_deb (
    .clk(clk), .arst_n(pwr_s), .btn_n_s(btn_s), .pressed(btn_qual)
  );

  rsup_hold_seq #(.LIMIT(HOLD_CYC)) u_seq (
    .clk(clk), .arst_n(pwr_s), .hold_req(btn_qual), .rst_n(seq_rst_n)
  );

  assign sys_rst_n = seq_rst_n;
  assign sys_rst   = ~seq_rst_n;
  assign thr_sel_o = tol_sel;
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
  parameter int HOLD_CYC = 250,
  parameter int DEB_CYC  = 20
) (
  input logic clk,
  input logic pwr_s,
  input logic btn_s,
  input logic qual,
  input logic sys_rst_n
);
  int hold_seen;
  int low_seen;

  always_ff @(posedge clk or negedge pwr_s) begin
    if (!pwr_s) begin
      hold_seen <= 0;
      low_seen  <= 0;
    end else begin
      if (qual)            hold_seen <= 0;
      else if (!sys_rst_n) hold_seen <= hold_seen + 1;
      else                 hold_seen <= 0;
      if (btn_s)                low_seen <= 0;
      else if (low_seen < DEB_CYC) low_seen <= low_seen + 1;
    end
  end

  // R2: an unsynchronized-good supply always means reset is asserted
  always @(posedge clk) begin
    if (!pwr_s) a_r2_rst_when_unpowered: assert (!sys_rst_n);
  end

  a_r3_full_hold: assert property (@(posedge clk) disable iff (!pwr_s)
    $rose(sys_rst_n) |-> hold_seen == HOLD_CYC);

  a_r4_qual_needs_window: assert property (@(posedge clk) disable iff (!pwr_s)
    $rose(qual) |-> low_seen >= DEB_CYC);

  a_r5_held_while_pressed: assert property (@(posedge clk) disable iff (!pwr_s)
    qual |=> !sys_rst_n);
endmodule

bind rst_supervisor rsup_checker #(.HOLD_CYC(HOLD_CYC), .DEB_CYC(DEB_CYC)) u_chk (
  .clk(clk), .pwr_s(pwr_s), .btn_s(btn_s), .qual(btn_qual), .sys_rst_n(sys_rst_n)
);

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
  localparam int PERIOD = 10;
  localparam int CLK_HZ = 1000;
  localparam int DEB    = 20;
  localparam int HOLD   = 250;

  logic clk = 1'b0;
  logic pwr_ok_async, tol_sel, btn_n_async;
  logic sys_rst_n, sys_rst, thr_sel_o;
  int checks = 0, failures = 0, r1_err = 0;

  always #(PERIOD/2) clk = ~clk;

  rst_supervisor #(.CLK_HZ(CLK_HZ), .DEB_MS(20), .HOLD_MS(250)) u_dut (
    .clk(clk), .pwr_ok_async(pwr_ok_async), .tol_sel(tol_sel), .btn_n_async(btn_n_async),
    .sys_rst_n(sys_rst_n), .sys_rst(sys_rst), .thr_sel_o(thr_sel_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 monitor, sampled away from the clock edge
  always begin
    @(posedge clk); #2;
    if (sys_rst !== ~sys_rst_n) r1_err++;
  end

  // power up: returns first edge at which reset is released (-1 if none)
  task automatic power_up(output int rel);
    rel = -1;
    @(negedge clk); pwr_ok_async = 1'b1;
    for (int e = 1; e <= HOLD + 10; e++) begin
      @(posedge clk); #1;
      if (sys_rst_n && rel < 0) rel = e;
    end
  endtask

  // press for L edges; first asserting edge and first releasing edge
  task automatic press(input int L, output int a, output int r);
    a = -1; r = -1;
    @(negedge clk); btn_n_async = 1'b0;
    for (int e = 1; e <= L + HOLD + 10; e++) begin
      @(posedge clk); #1;
      if (!sys_rst_n && a < 0) a = e;
      if (sys_rst_n && a >= 0 && r < 0) r = e;
      if (e == L) begin @(negedge clk); btn_n_async = 1'b1; end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rel, a, r;
    pwr_ok_async = 1'b1; btn_n_async = 1'b1; tol_sel = 1'b0;
    #1 pwr_ok_async = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    check("R2 reset state", sys_rst_n, 0);
    check("R1 reset state", sys_rst, 1);

    power_up(rel);
    check("R3 power-up release edge", rel, HOLD + 2);

    // R8 tolerance select forwarding
    tol_sel = 1'b1; #1; check("R8 thr_sel high", thr_sel_o, 1);
    tol_sel = 1'b0; #1; check("R8 thr_sel low", thr_sel_o, 0);

    // R4/R5/R6 sweep over press lengths around the debounce window
    for (int L = 1; L <= DEB + 4; L++) begin
      press(L, a, r);
      if (L < DEB) begin
        check("R6 short press ignored", a, -1);
      end else begin
        check("R4 press assert edge", a, DEB + 3);
        check("R5 press release edge", r, L + HOLD + 3);
      end
    end
    press(DEB + 150, a, r);
    check("R5 long press assert edge", a, DEB + 3);
    check("R5 long press release edge", r, DEB + 150 + HOLD + 3);

    // R7 retrigger with a new qualified press during the hold window
    @(negedge clk); btn_n_async = 1'b0;
    repeat (DEB + 5) @(posedge clk);
    @(negedge clk); btn_n_async = 1'b1;
    repeat (100) @(posedge clk);
    #1; check("R7 still held before retrigger", sys_rst_n, 0);
    press(DEB, a, r);
    check("R7 retrigger first sample low", a, 1);
    check("R7 retrigger release edge", r, DEB + HOLD + 3);

    // R2 supply drop while running
    @(negedge clk); pwr_ok_async = 1'b0; #1;
    check("R2 drop in run asserts at once", sys_rst_n, 0);
    repeat (3) @(posedge clk);
    power_up(rel);
    check("R3 release after drop", rel, HOLD + 2);

    // R7 supply dropout during the hold window
    @(negedge clk); pwr_ok_async = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); pwr_ok_async = 1'b1;
    repeat (100) @(posedge clk);
    #1; check("R7 held before mid-hold dropout", sys_rst_n, 0);
    @(negedge clk); pwr_ok_async = 1'b0; #1;
    check("R2 mid-hold dropout", sys_rst_n, 0);
    repeat (2) @(posedge clk);
    power_up(rel);
    check("R7 release after mid-hold dropout", rel, HOLD + 2);

    // R6 short press has no lasting effect after the run resumes
    press(DEB - 1, a, r);
    check("R6 boundary short press", a, -1);
    #1; check("R6 still released", sys_rst_n, 1);

    check("R1 complement monitor errors", r1_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule